// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block traverses the chain of extended-capability headers kept in the upper region of a 4 KB configuration space. The space sits in an attached memory that is addressed by dword and returns read data one cycle after the request. A search takes a 16-bit identifier and follows the chain from offset 256. It returns the offset of the first header that carries that identifier, or 0 when none does. It also returns the offset of the entry visited just before the result, so software or a neighbouring block can splice the chain.

An append operation adds a header at a caller-chosen offset. For any offset other than 256, the block first walks to the tail of the chain. It then patches only the next-pointer field of the tail entry and writes a fresh header with a zero next pointer at the new location. When the new offset is 256 itself, the block writes the header in place and keeps the next pointer already stored there. A pointer outside the legal window, a misaligned pointer, or a chain longer than the visit limit stops the operation with an error flag.

Top module: `ext_cap_walker`

## Requirements
- R1: Each header dword carries the identifier in bits 15:0, a version in bits 19:16 and the next offset in bits 31:20. A search with a nonzero identifier returns the offset of the first header whose identifier field matches, with `prev_off` set to the entry visited before it (0 when the match is at 256).
- R2: When the dword at offset 256 is all zeros, a search returns `found_off` = 0 and `prev_off` = 0 with `err` low.
- R3: When no header matches, the walk ends at the entry whose next offset is 0, and the search returns `found_off` = 0 with `prev_off` set to that last entry.
- R4: Identifier 0 never matches a header. A search for it returns `found_off` = 0 and `prev_off` = the last entry of the chain.
- R5: A next offset below 256, above 4088, or not a multiple of 4 ends the walk with `err` = 1 and both `found_off` and `prev_off` forced to 0. No read is ever issued below offset 256.
- R6: If the walk would have to visit more than 1024 headers, it ends with `err` = 1 after the 1024th read.
- R7: Append at an offset other than 256 does three things: it rewrites the tail entry with bits 31:20 set to the new offset and bits 19:0 unchanged, then writes {12'h000, version, identifier} at the new offset, then reports `found_off` = new offset and `prev_off` = tail offset.
- R8: Append at offset 256 writes {old bits 31:20 of offset 256, version, identifier} there. It reports `found_off` = 256 and `prev_off` = 0.
- R9: Append to an illegal new offset (below 256, above 4088 or misaligned), or append at a non-256 offset to an empty chain, sets `err` and leaves memory unwritten. The illegal-offset case completes in the cycle after the start.
- R10: `busy` is high from the cycle after an accepted start until `done`, and `done` is a one-cycle pulse. Each visited header costs two cycles (request, then evaluation), and each write costs one further cycle. Reads and writes never coincide.
- R11: After reset, `busy`, `done`, `err`, `found_off`, `prev_off` and the memory strobes are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_append | input | 1 | 0 = search, 1 = append |
| cap_id | input | 16 | Identifier to search for, or identifier of the new header |
| new_ver | input | 4 | Version field of the new header (append) |
| new_off | input | 12 | Byte offset of the new header (append) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation ended on a rule violation |
| found_off | output | 12 | Result offset |
| prev_off | output | 12 | Offset of the preceding entry |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Dword address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |

## Verification
A search that visits v headers raises `done` 2v cycles after the edge that takes `start`. A successful append elsewhere than 256 finishes at 2v+2 cycles, an append at 256 at 3 cycles, and a rejected new offset in the very next cycle. The bench derives this latency from its own walk of a shadow copy of the memory. At every falling edge in that window it compares `busy` and `done` with the expected values, and it samples the results in the cycle the pulse is due. After every operation it compares the whole memory with the shadow, so that stray or missing writes are caught.

// File: rtl/ext_cap_walker.sv
module ext_cap_walker #(
  parameter int OFF_W      = 12,
  parameter int BASE_OFF   = 256,
  parameter int MAX_VISITS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_append,
  input  logic [15:0]      cap_id,
  input  logic [3:0]       new_ver,
  input  logic [OFF_W-1:0] new_off,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [OFF_W-1:0] found_off,
  output logic [OFF_W-1:0] prev_off,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [OFF_W-3:0] mem_addr,
  output logic [OFF_W+19:0] mem_wdata,
  input  logic [OFF_W+19:0] mem_rdata
);
  localparam int CW      = $clog2(MAX_VISITS + 1);
  localparam int TOP_OFF = (1 << OFF_W) - 8;
  localparam logic [OFF_W-1:0] BASE = OFF_W'(BASE_OFF);

  typedef enum logic [2:0] {S_IDLE, S_RQ, S_WT, S_LINK, S_PLACE} state_t;
  state_t state;

  logic             op_q;
  logic [15:0]      id_q;
  logic [3:0]       ver_q;
  logic [OFF_W-1:0] noff_q, cur, prev_q, keep_next;
  logic [19:0]      tail_lo;
  logic [CW-1:0]    visits;

  function automatic logic off_bad(input logic [OFF_W-1:0] o);
    return (int'(o) < BASE_OFF) || (int'(o) > TOP_OFF) || (o[1:0] != 2'b00);
  endfunction

  wire [OFF_W-1:0] nxt = mem_rdata[OFF_W+19:20];

  assign busy      = (state != S_IDLE);
  assign mem_rd_en = (state == S_RQ);
  assign mem_wr_en = (state == S_LINK) || (state == S_PLACE);
  assign mem_addr  = (state == S_PLACE) ? noff_q[OFF_W-1:2] : cur[OFF_W-1:2];
  assign mem_wdata = (state == S_LINK) ? {noff_q, tail_lo} : {keep_next, ver_q, id_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      found_off <= '0;
      prev_off  <= '0;
      op_q      <= 1'b0;
      id_q      <= '0;
      ver_q     <= '0;
      noff_q    <= '0;
      cur       <= '0;
      prev_q    <= '0;
      keep_next <= '0;
      tail_lo   <= '0;
      visits    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q      <= op_append;
          id_q      <= cap_id;
          ver_q     <= new_ver;
          noff_q    <= new_off;
          cur       <= BASE;
          prev_q    <= '0;
          keep_next <= '0;
          visits    <= '0;
          if (op_append && off_bad(new_off)) begin
            err <= 1'b1; found_off <= '0; prev_off <= '0; done <= 1'b1;
          end else begin
            state <= S_RQ;
          end
        end
        S_RQ: state <= S_WT;
        S_WT: begin
          visits <= visits + 1'b1;
          if (op_q && noff_q == BASE) begin
            keep_next <= nxt;
            state     <= S_PLACE;
          end else if (cur == BASE && mem_rdata == '0) begin
            err <= op_q; found_off <= '0; prev_off <= '0; done <= 1'b1;
            state <= S_IDLE;
          end else if (!op_q && id_q != 16'h0 && mem_rdata[15:0] == id_q) begin
            err <= 1'b0; found_off <= cur; prev_off <= prev_q; done <= 1'b1;
            state <= S_IDLE;
          end else if (nxt == '0) begin
            if (op_q) begin
              tail_lo <= mem_rdata[19:0];
              state   <= S_LINK;
            end else begin
              err <= 1'b0; found_off <= '0; prev_off <= cur; done <= 1'b1;
              state <= S_IDLE;
            end
          end else if (off_bad(nxt) || visits == CW'(MAX_VISITS - 1)) begin
            err <= 1'b1; found_off <= '0; prev_off <= '0; done <= 1'b1;
            state <= S_IDLE;
          end else begin
            prev_q <= cur;
            cur    <= nxt;
            state  <= S_RQ;
          end
        end
        S_LINK: state <= S_PLACE;
        S_PLACE: begin
          err       <= 1'b0;
          found_off <= noff_q;
          prev_off  <= (noff_q == BASE) ? '0 : cur;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module ext_cap_walker_chk #(
  parameter int OFF_W    = 12,
  parameter int BASE_OFF = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [OFF_W-1:0] found_off,
  input logic [OFF_W-1:0] prev_off,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [OFF_W-3:0] mem_addr
);
  localparam int BASE_DW = BASE_OFF / 4;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_ends_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en && !mem_wr_en);
  assert_err_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> found_off == '0 && prev_off == '0);
  assert_rd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> int'(mem_addr) >= BASE_DW);
  assert_wr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> int'(mem_addr) >= BASE_DW);
endmodule

bind ext_cap_walker ext_cap_walker_chk #(.OFF_W(OFF_W), .BASE_OFF(BASE_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .found_off(found_off), .prev_off(prev_off),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr)
);

// File: tb/test_ext_cap_walker.sv
`timescale 1ns/1ps
module test_ext_cap_walker;
  localparam int MAXV = 1024;

  logic clk = 0, rst_n = 0, start = 0, op_append = 0;
  logic [15:0] cap_id = 0;
  logic [3:0]  new_ver = 0;
  logic [11:0] new_off = 0;
  logic busy, done, err, mem_rd_en, mem_wr_en;
  logic [11:0] found_off, prev_off;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic [31:0] shadow [0:1023];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ext_cap_walker i_ext_cap_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .op_append(op_append),
    .cap_id(cap_id), .new_ver(new_ver), .new_off(new_off),
    .busy(busy), .done(done), .err(err), .found_off(found_off), .prev_off(prev_off),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input int off, input logic [31:0] v);
    mem[off/4] = v;
    shadow[off/4] = v;
  endtask

  function automatic bit bad(input int o);
    return o < 256 || o > 4088 || (o % 4) != 0;
  endfunction

  int m_found, m_prev, m_vis, m_lat;
  bit m_err, m_empty;
  logic [31:0] m_hdr;

  task automatic walk(input int id);
    int cur = 256, prv = 0, nx;
    m_vis = 0; m_err = 0; m_empty = 0; m_found = 0; m_prev = 0;
    forever begin
      m_hdr = shadow[cur/4];
      m_vis++;
      if (cur == 256 && m_hdr == 0) begin m_empty = 1; return; end
      if (id != 0 && int'(m_hdr[15:0]) == id) begin m_found = cur; m_prev = prv; return; end
      nx = int'(m_hdr[31:20]);
      if (nx == 0) begin m_prev = cur; return; end
      if (bad(nx) || m_vis == MAXV) begin m_err = 1; m_prev = 0; return; end
      prv = cur; cur = nx;
    end
  endtask

  task automatic model(input bit op, input int id, input int ver, input int noff);
    if (!op) begin
      walk(id);
      m_lat = 2 * m_vis;
    end else if (bad(noff)) begin
      m_err = 1; m_found = 0; m_prev = 0; m_lat = 0;
    end else if (noff == 256) begin
      m_hdr = shadow[64];
      shadow[64] = {m_hdr[31:20], ver[3:0], id[15:0]};
      m_err = 0; m_found = 256; m_prev = 0; m_lat = 3;
    end else begin
      walk(0);
      m_lat = 2 * m_vis;
      if (m_empty) m_err = 1;
      if (!m_err) begin
        shadow[m_prev/4] = {noff[11:0], m_hdr[19:0]};
        shadow[noff/4]   = {12'h000, ver[3:0], id[15:0]};
        m_found = noff;
        m_lat   = m_lat + 2;
      end
    end
  endtask

  task automatic run_op(input bit op, input int id, input int ver, input int noff, input string tag);
    bit tim_ok = 1;
    int mism = 0;
    model(op, id, ver, noff);
    @(negedge clk);
    start = 1; op_append = op; cap_id = id[15:0]; new_ver = ver[3:0]; new_off = noff[11:0];
    for (int k = 0; k <= m_lat; k++) begin
      @(negedge clk);
      start = 0;
      if (busy !== (k < m_lat) || done !== (k == m_lat)) tim_ok = 0;
    end
    chk(tim_ok, tag, "busy/done timing latency", 0, m_lat);
    chk(err === m_err, tag, "err", int'(err), int'(m_err));
    chk(int'(found_off) == m_found, tag, "found_off", int'(found_off), m_found);
    chk(int'(prev_off) == m_prev, tag, "prev_off", int'(prev_off), m_prev);
    for (int i = 0; i < 1024; i++) if (mem[i] !== shadow[i]) mism++;
    chk(mism == 0, tag, "memory words differing", mism, 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = 0; shadow[i] = 0; end
    mem_rdata = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && found_off == 0 && prev_off == 0 && !mem_rd_en && !mem_wr_en,
        "R11", "reset outputs", {busy, done, err, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1;
    run_op(0, 16'h0005, 0, 0, "R2");
    run_op(1, 16'h0033, 1, 12'h200, "R9");
    run_op(1, 16'h0010, 1, 256, "R8");
    run_op(1, 16'h0011, 1, 12'h140, "R7");
    run_op(1, 16'h0012, 3, 12'h300, "R7");
    run_op(0, 16'h0012, 0, 0, "R1");
    run_op(0, 16'h0011, 0, 0, "R1");
    run_op(0, 16'h0010, 0, 0, "R1");
    run_op(0, 16'h0077, 0, 0, "R3");
    run_op(0, 16'h0000, 0, 0, "R4");
    run_op(1, 16'h0020, 2, 256, "R8");
    run_op(0, 16'h0020, 0, 0, "R1");
    run_op(1, 16'h0044, 1, 12'h102, "R9");
    run_op(1, 16'h0044, 1, 12'h0F0, "R9");
    run_op(1, 16'h0044, 1, 12'hFFC, "R9");
    poke(12'h300, {12'h0F0, 4'h3, 16'h0012});
    run_op(0, 16'h0099, 0, 0, "R5");
    poke(12'h300, {12'h302, 4'h3, 16'h0012});
    run_op(0, 16'h0099, 0, 0, "R5");
    poke(12'h300, {12'hFFC, 4'h3, 16'h0012});
    run_op(0, 16'h0099, 0, 0, "R5");
    poke(12'h300, {12'h100, 4'h3, 16'h0012});
    run_op(0, 16'h0099, 0, 0, "R6");
    run_op(0, 16'h0012, 0, 0, "R6");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule